// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory built for a bus that never idles between a read and a write. Every enabled clock edge can carry a new command. A read returns its word two enabled edges after the command, through a registered output stage. A write takes its address and byte mask at the command edge, but its data two enabled edges later. Because of this, the data bus carries one word per cycle whatever the mix of reads and writes, and no turnaround slot is needed.

A command is loaded when the load strobe `adv` is low. A load with all three chip selects active starts a read or a write. A load with any select inactive starts a deselect. When `adv` is high, the previous operation continues as a four-beat burst. The burst address is generated internally in linear or interleaved order and wraps back to its start. A clock-enable freezes the whole pipeline. An asynchronous output enable gates the result. Each word holds four 9-bit lanes, and the ninth bit of each lane is stored like any other bit.

Top module: `zt_sram`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pipeline is emptied: `dout_valid` is low and `dout` is zero after that edge.
- R2: A read command (`cke_n`=0, `adv`=0, `cs1_n`=0, `cs2`=1, `cs3_n`=0, `we_n`=1) at enabled edge k puts the word on `dout`, with `dout_valid` high, after enabled edge k+2.
- R3: A write command at enabled edge k takes its data from `din` at enabled edge k+2. A later read returns that data. `dout_valid` is low after edge k+2.
- R4: On a write, lane i (bits 9i+8 down to 9i) is written only when `bw_n[i]` is 0. The other lanes keep their old contents.
- R5: Reads and writes may follow each other on consecutive enabled edges in any order, with no idle cycle, and each returns correct data.
- R6: A read issued one or two edges after a write to the same address returns the newly written lanes merged with the old ones. It never returns the stale word.
- R7: An edge with `cke_n`=1 has no effect. No command is taken, `din` is ignored, and `dout`/`dout_valid` keep their values.
- R8: A load with any chip select inactive is a deselect. It writes nothing, even when `we_n` is low, and `dout_valid` is low after edge k+2.
- R9: With `oe_n`=1, `dout` is zero and `dout_valid` is low at once, without a clock edge. Setting `oe_n`=0 again restores the pending word.
- R10: With `adv`=1 the previous operation continues at the next burst address. The two low address bits become start+n mod 4 when `ilv`=0, or start XOR n when `ilv`=1, where n counts beats since the load. The upper bits are held, and the fifth beat wraps back to the start.
- R11: All 36 bits, including the ninth bit of each lane, are stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 loads a new command, 1 continues the burst |
| we_n | input | 1 | 0 writes, 1 reads (sampled on load) |
| bw_n | input | 4 | Per-lane write enables, active low |
| ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 10 | Word address |
| din | input | 36 | Write data, due two enabled edges after the command |
| dout | output | 36 | Read data, zero when not valid |
| dout_valid | output | 1 | Read data present on `dout` |

## Verification
A wrong slot in the command pipeline shows up on `dout_valid` exactly two enabled edges after the command that fed it, either as a missing read or as a phantom one. A write pipeline stage that holds the wrong address, mask or timing corrupts the array silently. It becomes visible only when a later read returns the wrong lanes, so every write is read back, both right behind it and later. A stall that fails to freeze a register changes `dout` during the very next stalled cycle.

// File: rtl/zt_burst.sv
module zt_burst #(
  parameter int ADDR_W  = 10,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] start,
  output logic [ADDR_W-1:0] cyc_addr
);
  logic [ADDR_W-1:0]  base;
  logic [BURST_W-1:0] cnt, nxt, low;

  assign nxt      = cnt + 1'b1;
  assign low      = ilv ? (base[BURST_W-1:0] ^ nxt) : (base[BURST_W-1:0] + nxt);
  assign cyc_addr = load ? start : {base[ADDR_W-1:BURST_W], low};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      cnt  <= '0;
    end else if (en) begin
      if (load) begin
        base <= start;
        cnt  <= '0;
      end else begin
        cnt  <= nxt;
      end
    end
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke_n,
  input  logic                     cs1_n,
  input  logic                     cs2,
  input  logic                     cs3_n,
  input  logic                     adv,
  input  logic                     we_n,
  input  logic [LANES-1:0]         bw_n,
  input  logic                     ilv,
  input  logic                     oe_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  din,
  output logic [LANES*LANE_W-1:0]  dout,
  output logic                     dout_valid
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR} op_t;

  logic [DATA_W-1:0] mem [DEPTH];

  wire en   = !cke_n;
  wire load = !adv;
  wire sel  = !cs1_n && cs2 && !cs3_n;

  op_t               op_q, op_now, s1_op, s2_op;
  logic [ADDR_W-1:0] cyc_addr, s1_addr, s2_addr;
  logic [LANES-1:0]  s1_be, s2_be;
  logic [DATA_W-1:0] rd_mrg, rd_buf, out_q;
  logic              out_v;

  zt_burst #(.ADDR_W(ADDR_W), .BURST_W(2)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .load     (load),
    .ilv      (ilv),
    .start    (addr),
    .cyc_addr (cyc_addr)
  );

  always_comb begin
    if (!load)     op_now = op_q;
    else if (!sel) op_now = OP_NONE;
    else           op_now = we_n ? OP_RD : OP_WR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= OP_NONE;
      s1_op <= OP_NONE;
      s2_op <= OP_NONE;
      out_v <= 1'b0;
    end else if (en) begin
      op_q  <= op_now;
      s1_op <= op_now;
      s2_op <= s1_op;
      out_v <= (s2_op == OP_RD);
    end
  end

  always_comb begin
    rd_mrg = mem[s1_addr];
    if (s2_op == OP_WR && s2_addr == s1_addr)
      for (int i = 0; i < LANES; i++)
        if (s2_be[i]) rd_mrg[i*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s1_addr <= cyc_addr;
      s1_be   <= ~bw_n;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      rd_buf  <= rd_mrg;
      if (s2_op == OP_RD) out_q <= rd_buf;
      if (rst_n && s2_op == OP_WR)
        for (int i = 0; i < LANES; i++)
          if (s2_be[i]) mem[s2_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
    end
  end

  assign dout_valid = out_v && !oe_n;
  assign dout       = dout_valid ? out_q : '0;
endmodule

module zt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_n,
  input logic              adv,
  input logic              cs1_n,
  input logic              cs2,
  input logic              cs3_n,
  input logic              we_n,
  input logic              out_v,
  input logic [DATA_W-1:0] out_q
);
  wire ld     = !cke_n && !adv;
  wire act    = !cs1_n && cs2 && !cs3_n;
  wire rd_cmd = ld && act && we_n;
  wire wr_cmd = ld && act && !we_n;
  wire ds_cmd = ld && !act;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !out_v);

  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd ##1 !cke_n ##1 !cke_n |=> out_v);

  p_wr_no_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd ##1 !cke_n ##1 !cke_n |=> !out_v);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(out_v) && $stable(out_q));

  p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ds_cmd ##1 !cke_n ##1 !cke_n |=> !out_v);
endmodule

bind zt_sram zt_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cke_n (cke_n),
  .adv   (adv),
  .cs1_n (cs1_n),
  .cs2   (cs2),
  .cs3_n (cs3_n),
  .we_n  (we_n),
  .out_v (out_v),
  .out_q (out_q)
);

// File: tb/test_zt_sram.sv
module test_zt_sram;
  localparam logic [35:0] GARB = 36'h9_A5A5_A5A5;
  localparam logic [2:0]  SEL  = 3'b010;

  logic        clk = 1'b0;
  logic        rst_n, cke_n, cs1_n, cs2, cs3_n, adv, we_n, ilv, oe_n;
  logic [3:0]  bw_n;
  logic [9:0]  addr;
  logic [35:0] din, dout;
  logic        dout_valid;

  zt_sram i_zt_sram (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  logic [35:0] ref_mem [1024];
  int          m_op = 0;
  logic [9:0]  m_base = '0;
  logic [1:0]  m_cnt = '0;
  logic [35:0] wq0 = GARB, wq1 = GARB;
  bit          ev0 = 0, ev1 = 0, cur_v = 0;
  logic [35:0] ed0 = '0, ed1 = '0, cur_d = '0;

  task automatic chk(input bit ok, input logic [36:0] act, input logic [36:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual valid/data=%0b/%h expected %0b/%h", tag, act[36], act[35:0], exp[36], exp[35:0]);
    end
  endtask

  task automatic check_out();
    if (cur_v) chk(dout_valid === 1'b1 && dout === cur_d, {dout_valid, dout}, {1'b1, cur_d});
    else       chk(dout_valid === 1'b0 && dout === '0,    {dout_valid, dout}, {1'b0, 36'h0});
  endtask

  task automatic cyc(input bit ck, input bit ad, input logic [2:0] cs, input bit we,
                     input logic [3:0] bw, input logic [9:0] a, input logic [35:0] wd);
    logic [9:0]  ma;
    bit          ev;
    logic [35:0] ed;
    @(negedge clk);
    check_out();
    cke_n = ck; adv = ad; {cs1_n, cs2, cs3_n} = cs; we_n = we; bw_n = bw; addr = a;
    din = ck ? GARB : wq0;
    if (!ck) begin
      if (!ad) begin
        m_op = (cs != SEL) ? 0 : (we ? 1 : 2);
        m_base = a; m_cnt = '0; ma = a;
      end else begin
        m_cnt = m_cnt + 1'b1;
        ma = {m_base[9:2], ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
      end
      ev = (m_op == 1);
      ed = ev ? ref_mem[ma] : '0;
      if (m_op == 2)
        for (int i = 0; i < 4; i++)
          if (!bw[i]) ref_mem[ma][i*9 +: 9] = wd[i*9 +: 9];
      cur_v = ev0; cur_d = ed0;
      ev0 = ev1; ed0 = ed1;
      ev1 = ev;  ed1 = ed;
      wq0 = wq1;
      wq1 = (m_op == 2) ? wd : GARB;
    end
    @(posedge clk);
    #1 cke_n = 1'b1;
  endtask

  task automatic wr(input logic [9:0] a, input logic [35:0] d, input logic [3:0] bw = 4'h0);
    cyc(0, 0, SEL, 0, bw, a, d);
  endtask
  task automatic rd(input logic [9:0] a);
    cyc(0, 0, SEL, 1, 4'hF, a, GARB);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 3'b110, 1, 4'hF, 10'h3FF, GARB);
  endtask

  task automatic t_reset();
    tag = "R1";
    rst_n = 0; cke_n = 1; adv = 0; {cs1_n, cs2, cs3_n} = SEL; we_n = 1; bw_n = 4'hF;
    ilv = 0; oe_n = 0; addr = '0; din = GARB;
    for (int i = 0; i < 1024; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dout_valid === 1'b0 && dout === '0, {dout_valid, dout}, 37'h0);
    for (int i = 0; i < 1024; i++) begin
      {cs1_n, cs2, cs3_n} = SEL; cke_n = 0; we_n = 0; bw_n = 4'h0; addr = 10'(i); din = '0;
      rst_n = (i != 0);
      @(negedge clk);
    end
    cke_n = 1; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(dout_valid === 1'b0 && dout === '0, {dout_valid, dout}, 37'h0);
  endtask

  task automatic t_write_read();
    tag = "R3";
    wr(10'h010, 36'h1_2345_6789); wr(10'h011, 36'h8_7654_3210); wr(10'h3FE, 36'hF_FFFF_FFFF);
    idle(2);
    tag = "R2";
    rd(10'h010); rd(10'h011); rd(10'h3FE); rd(10'h012);
    idle(3);
  endtask

  task automatic t_bytes();
    tag = "R11";
    wr(10'h020, 36'hF_FFFF_FFFF);
    wr(10'h021, 36'h8_0402_0100);
    idle(1);
    rd(10'h020); rd(10'h021);
    tag = "R4";
    wr(10'h020, 36'h0_0000_0000, 4'b1010);
    wr(10'h021, 36'h5_5555_5555, 4'b0111);
    idle(1);
    rd(10'h020); rd(10'h021);
    idle(3);
  endtask

  task automatic t_mixed();
    tag = "R5";
    wr(10'h030, 36'h1_1111_1111); rd(10'h010); wr(10'h031, 36'h2_2222_2222); rd(10'h030);
    rd(10'h031); wr(10'h032, 36'h3_3333_3333); rd(10'h032);
    tag = "R6";
    wr(10'h040, 36'hA_BCDE_F012); rd(10'h040);
    wr(10'h040, 36'h0_0000_0000, 4'b0110); rd(10'h040);
    wr(10'h041, 36'h7_7777_7777); idle(1); rd(10'h041);
    wr(10'h041, 36'hC_CCCC_CCCC, 4'b1110); rd(10'h041); rd(10'h041);
    idle(3);
  endtask

  task automatic t_stall();
    tag = "R7";
    wr(10'h050, 36'h1_0203_0405);
    cyc(1, 0, SEL, 0, 4'h0, 10'h050, GARB);
    rd(10'h050);
    cyc(1, 0, SEL, 0, 4'h0, 10'h051, GARB);
    cyc(1, 0, SEL, 0, 4'h0, 10'h051, GARB);
    rd(10'h051);
    cyc(1, 1, SEL, 1, 4'hF, 10'h000, GARB);
    idle(2);
    cyc(1, 0, SEL, 0, 4'h0, 10'h051, GARB);
    cyc(1, 0, SEL, 0, 4'h0, 10'h051, GARB);
    idle(1);
    rd(10'h051); rd(10'h050);
    idle(3);
  endtask

  task automatic t_deselect();
    tag = "R8";
    cyc(0, 0, 3'b110, 0, 4'h0, 10'h010, GARB);
    cyc(0, 0, 3'b000, 0, 4'h0, 10'h011, GARB);
    cyc(0, 0, 3'b011, 0, 4'h0, 10'h020, GARB);
    cyc(0, 1, SEL, 0, 4'h0, 10'h000, GARB);
    idle(1);
    rd(10'h010); rd(10'h011); rd(10'h020); rd(10'h021);
    idle(3);
  endtask

  task automatic t_burst();
    tag = "R10";
    ilv = 0;
    wr(10'h066, 36'h0_0000_0A00);
    cyc(0, 1, SEL, 0, 4'h0, 10'h000, 36'h0_0000_0A01);
    cyc(0, 1, 3'b110, 1, 4'h0, 10'h000, 36'h0_0000_0A02);
    cyc(0, 1, SEL, 0, 4'h0, 10'h3FF, 36'h0_0000_0A03);
    cyc(0, 1, SEL, 0, 4'h0, 10'h000, 36'h0_0000_0A04);
    idle(1);
    rd(10'h064); rd(10'h065); rd(10'h066); rd(10'h067);
    idle(2);
    ilv = 1;
    wr(10'h071, 36'h0_0000_0B00);
    cyc(0, 1, SEL, 0, 4'h0, 10'h000, 36'h0_0000_0B01);
    cyc(0, 1, SEL, 0, 4'h0, 10'h000, 36'h0_0000_0B02);
    cyc(0, 1, SEL, 0, 4'h0, 10'h000, 36'h0_0000_0B03);
    idle(1);
    rd(10'h070); rd(10'h071); rd(10'h072); rd(10'h073);
    rd(10'h072);
    for (int i = 0; i < 4; i++) cyc(0, 1, SEL, 0, 4'h0, 10'h000, GARB);
    idle(3);
    ilv = 0;
  endtask

  task automatic t_oe();
    tag = "R9";
    rd(10'h040); idle(2);
    @(negedge clk);
    #1 oe_n = 1;
    #1 chk(dout_valid === 1'b0 && dout === '0, {dout_valid, dout}, 37'h0);
    oe_n = 0;
    #1 chk(dout_valid === 1'b1 && dout === ev0_d(), {dout_valid, dout}, {1'b1, ev0_d()});
    idle(3);
  endtask

  function automatic logic [35:0] ev0_d();
    return ref_mem[10'h040];
  endfunction

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_write_read();
    t_bytes();
    t_mixed();
    t_stall();
    t_deselect();
    t_burst();
    t_oe();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule